// File: doc/BRIEF.md
# Programmable Low-Memory Chip-Select Unit

This unit checks every bus address against a memory window that always starts at address zero and whose upper bound is set by a 16-bit control register. When an address falls inside the window, the unit drives an active-low select. On an access cycle that selects the window, it holds a ready handshake low for a programmed number of T-state ticks. In one ready mode it also waits for an external ready input. Two more flags follow a hit. One tells the bus driver to leave out the address phase on the low multiplexed byte. The other marks the access as going to pseudo-static RAM.

The bus cycle sequencer sits outside the block. It gives a one-clock cycle-start strobe together with the address, and a tick for each T-state. The select comes out of reset inert. It stays that way until software reads or writes the control register once. The address-phase suppression is allowed only if a strap input was high while reset was released. All ports are plain control and status pins, so no valid/ready streaming interface applies.

Top module: `lcs_unit`

## Requirements
- R1: The window covers addresses 0 through an end address chosen by control bits 14:12: code 000 ends at 0FFFFh, 001 at 1FFFFh, 011 at 3FFFFh and 111 at 7FFFFh. `lcs_n` is low exactly when an armed unit sees an address at or below the end.
- R2: Any other size code selects the window given by the run of ones counted up from bit 12: 010, 100 and 110 give 64 KB, and 101 gives 128 KB.
- R3: From reset, `lcs_n` stays high for every address. Any register access, read or write, arms the unit, and the select decodes from the clock after that access.
- R4: Control bits 1:0 are an unsigned wait count N. After a cycle start that hits the window, `bus_rdy` is low for exactly N T-state ticks. The count does not move on clocks without a tick.
- R5: With control bit 2 = 1, `bus_rdy` also stays low after the count runs out until `ext_rdy` is high. With bit 2 = 0, `ext_rdy` is ignored.
- R6: A cycle start that misses the window leaves `bus_rdy` high.
- R7: `ad_lo_addr_off` is high when control bit 7 is 1, the window is hit, and `strap_aden` was high at reset release. Otherwise it is low.
- R8: `psram_hit` is high when control bit 6 is 1 and the window is hit.
- R9: Bits 15, 11:8 and 5:3 always read as 1, and writes to them are ignored. The register reads FFFFh after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_aden | input | 1 | Strap, captured while reset is held, that allows address suppression |
| reg_req | input | 1 | Register access strobe (read or write) |
| reg_we | input | 1 | Write qualifier for `reg_req` |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| addr | input | 20 | Bus address |
| cyc_start | input | 1 | One-clock start of a bus cycle |
| t_tick | input | 1 | T-state tick that advances the wait count |
| ext_rdy | input | 1 | External ready |
| lcs_n | output | 1 | Active-low window select |
| bus_rdy | output | 1 | Ready to the bus sequencer |
| ad_lo_addr_off | output | 1 | Suppress address phase on the low multiplexed byte |
| psram_hit | output | 1 | Hit on a pseudo-static RAM window |

## Verification
The hardest state to reach from the ports is the interaction between the strap, which is sampled only at reset release, and the arming flag, which every reset clears. Exercising both strap values means re-entering reset partway through the run and then accessing the register again before any select can be seen. The bench runs directed passes with the strap high and then low. It then uses seeded random register values, with addresses drawn near every window edge, to cover the size codes that are not in the standard set.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int SIZE_W = 3;
  localparam int RUN_W  = $clog2(SIZE_W + 1);
  localparam int WS_W   = 2;
  localparam logic [15:0] RSV_MASK = 16'h8F38;
  localparam logic [15:0] CTRL_RST = 16'hFFFF;

  typedef struct packed {
    logic              rsv_top;
    logic [SIZE_W-1:0] size;
    logic [3:0]        rsv_mid;
    logic              adr_off;
    logic              psram;
    logic [2:0]        rsv_low;
    logic              rdy_ext;
    logic [WS_W-1:0]   ws;
  } ctrl_t;

  // Length of the run of ones starting at the least significant bit.
  function automatic logic [RUN_W-1:0] size_run(input logic [SIZE_W-1:0] code);
    logic stop;
    size_run = '0;
    stop = 1'b0;
    for (int i = 0; i < SIZE_W; i++) begin
      if (!code[i]) stop = 1'b1;
      if (!stop) size_run = size_run + 1'b1;
    end
  endfunction
endpackage

// File: rtl/lcs_regs.sv
module lcs_regs
  import lcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_in,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output ctrl_t       ctrl_o,
  output logic        armed_o,
  output logic        strap_o
);
  ctrl_t ctrl_q;
  logic  armed_q;
  logic  strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_t'(CTRL_RST);
      armed_q <= 1'b0;
    end else begin
      if (reg_req) armed_q <= 1'b1;
      if (reg_req && reg_we) ctrl_q <= ctrl_t'(reg_wdata | RSV_MASK);
    end
  end

  // Strap is followed while reset is held; the last value before release sticks.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  assign ctrl_o  = ctrl_q;
  assign armed_o = armed_q;
  assign strap_o = strap_q;
endmodule

// File: rtl/lcs_decode.sv
module lcs_decode
  import lcs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BASE_LOG = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              armed,
  input  logic [SIZE_W-1:0] size,
  output logic              hit
);
  localparam int STEPS = SIZE_W + 1;
  logic [STEPS-1:0] below;

  genvar g;
  generate
    for (g = 0; g < STEPS; g++) begin : g_step
      if (BASE_LOG + g >= ADDR_W) begin : g_full
        assign below[g] = 1'b1;
      end else begin : g_cmp
        assign below[g] = (addr[ADDR_W-1:BASE_LOG+g] == '0);
      end
    end
  endgenerate

  logic [RUN_W-1:0] run;
  assign run = size_run(size);
  assign hit = armed & below[run];
endmodule

// File: rtl/lcs_wait.sv
module lcs_wait
  import lcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic            hit,
  input  logic [WS_W-1:0] ws,
  input  logic            ext_mode,
  input  logic            t_tick,
  input  logic            ext_rdy,
  output logic            bus_rdy
);
  logic            active_q;
  logic            ext_q;
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ext_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (cyc_start) begin
      active_q <= hit;
      ext_q    <= ext_mode;
      cnt_q    <= hit ? ws : '0;
    end else if (active_q && t_tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bus_rdy = !active_q || (cnt_q == '0 && (!ext_q || ext_rdy));
endmodule

// File: rtl/lcs_unit.sv
module lcs_unit
  import lcs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BASE_LOG = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_aden,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cyc_start,
  input  logic              t_tick,
  input  logic              ext_rdy,
  output logic              lcs_n,
  output logic              bus_rdy,
  output logic              ad_lo_addr_off,
  output logic              psram_hit
);
  ctrl_t ctrl;
  logic  armed;
  logic  strap_q;
  logic  hit;

  lcs_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_in (strap_aden),
    .reg_req  (reg_req),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .ctrl_o   (ctrl),
    .armed_o  (armed),
    .strap_o  (strap_q)
  );

  lcs_decode #(.ADDR_W(ADDR_W), .BASE_LOG(BASE_LOG)) u_dec (
    .addr (addr),
    .armed(armed),
    .size (ctrl.size),
    .hit  (hit)
  );

  lcs_wait u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .hit      (hit),
    .ws       (ctrl.ws),
    .ext_mode (ctrl.rdy_ext),
    .t_tick   (t_tick),
    .ext_rdy  (ext_rdy),
    .bus_rdy  (bus_rdy)
  );

  assign reg_rdata      = ctrl;
  assign lcs_n          = ~hit;
  assign ad_lo_addr_off = hit & strap_q & ctrl.adr_off;
  assign psram_hit      = hit & ctrl.psram;
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
  parameter int ADDR_W   = 20,
  parameter int BASE_LOG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic [15:0]       reg_rdata,
  input logic [ADDR_W-1:0] addr,
  input logic              cyc_start,
  input logic              lcs_n,
  input logic              bus_rdy,
  input logic              ad_lo_addr_off,
  input logic              psram_hit
);
  logic touched;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) touched <= 1'b0;
    else if (reg_req) touched <= 1'b1;
  end

  a_r3_inert_until_access: assert property (@(posedge clk) disable iff (!rst_n)
    !touched |-> lcs_n);

  a_r1_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !lcs_n |-> (addr >> (BASE_LOG + 3)) == '0);

  a_r9_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 16'h8F38) == 16'h8F38);

  a_r7_adoff_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ad_lo_addr_off |-> (!lcs_n && reg_rdata[7]));

  a_r8_psram_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    psram_hit |-> (!lcs_n && reg_rdata[6]));

  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !lcs_n && reg_rdata[1:0] != 2'b00) |=> !bus_rdy);

  a_r6_miss_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && lcs_n) |=> bus_rdy);
endmodule

bind lcs_unit lcs_checker #(.ADDR_W(ADDR_W), .BASE_LOG(BASE_LOG)) u_lcs_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_req       (reg_req),
  .reg_rdata     (reg_rdata),
  .addr          (addr),
  .cyc_start     (cyc_start),
  .lcs_n         (lcs_n),
  .bus_rdy       (bus_rdy),
  .ad_lo_addr_off(ad_lo_addr_off),
  .psram_hit     (psram_hit)
);

// File: tb/test_lcs_unit.sv
module test_lcs_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_aden = 1'b1;
  logic        reg_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [19:0] addr = '0;
  logic        cyc_start = 1'b0;
  logic        t_tick = 1'b1;
  logic        ext_rdy = 1'b1;
  logic        lcs_n, bus_rdy, ad_lo_addr_off, psram_hit;

  int checks = 0;
  int errors = 0;
  bit strap_now = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  lcs_unit i_lcs_unit (
    .clk(clk), .rst_n(rst_n), .strap_aden(strap_aden),
    .reg_req(reg_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .addr(addr), .cyc_start(cyc_start),
    .t_tick(t_tick), .ext_rdy(ext_rdy), .lcs_n(lcs_n), .bus_rdy(bus_rdy),
    .ad_lo_addr_off(ad_lo_addr_off), .psram_hit(psram_hit)
  );

  function automatic logic [20:0] win_lim(input logic [15:0] c);
    int run = 0;
    if (c[12]) begin
      run = 1;
      if (c[13]) begin
        run = 2;
        if (c[14]) run = 3;
      end
    end
    return 21'(1) << (16 + run);
  endfunction

  function automatic bit exp_hit(input logic [15:0] c, input logic [19:0] a);
    return {1'b0, a} < win_lim(c);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_n = 1'b0;
    strap_aden = s;
    strap_now = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic reg_access(input bit we, input logic [15:0] d);
    @(negedge clk);
    reg_req = 1'b1;
    reg_we = we;
    reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0;
    reg_we = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [15:0] c, input logic [19:0] a);
    bit h;
    addr = a;
    #1;
    h = exp_hit(c, a);
    check({tag, " lcs_n"}, 32'(lcs_n), 32'(!h));
    check({tag, " psram R8"}, 32'(psram_hit), 32'(h & c[6]));
    check({tag, " adoff R7"}, 32'(ad_lo_addr_off), 32'(h & c[7] & strap_now));
  endtask

  // Start a cycle and count the clocks bus_rdy stays low (ticks every clock).
  task automatic wait_len(input logic [19:0] a, output int n);
    @(negedge clk);
    addr = a;
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    n = 0;
    #1;
    while (!bus_rdy && n < 20) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c;
    int n;
    void'($urandom(32'd4242));
    do_reset(1'b1);

    // R9 reset value, R3 inert
    #1;
    check("R9 reset value", 32'(reg_rdata), 32'hFFFF);
    addr = 20'h00000; #1; check("R3 inert at 0", 32'(lcs_n), 1);
    addr = 20'h7FFFF; #1; check("R3 inert at end", 32'(lcs_n), 1);
    @(negedge clk);
    cyc_start = 1'b1; addr = 20'h00010;
    @(negedge clk);
    cyc_start = 1'b0; #1;
    check("R3 inert cycle leaves ready", 32'(bus_rdy), 1);

    // R3: a read arms
    reg_access(1'b0, 16'h0000);
    addr = 20'h00000; #1;
    check("R3 armed by read", 32'(lcs_n), 0);

    // R9: write reserved zeros
    reg_access(1'b1, 16'h0000);
    #1;
    check("R9 reserved forced", 32'(reg_rdata), 32'h8F38);

    // R1/R2: every size code at its boundary
    for (int code = 0; code < 8; code++) begin
      c = 16'h8F38 | 16'(code << 12) | 16'h00C0;
      reg_access(1'b1, c);
      probe((code == 0 || code == 1 || code == 3 || code == 7) ? "R1 end" : "R2 end",
            c, 20'(win_lim(c) - 1));
      probe((code == 0 || code == 1 || code == 3 || code == 7) ? "R1 past" : "R2 past",
            c, 20'(win_lim(c)));
    end

    // R4: each wait count, ready mode 0
    for (int ws = 0; ws < 4; ws++) begin
      c = 16'h8F38 | 16'h7000 | 16'(ws);
      reg_access(1'b1, c);
      wait_len(20'h01234, n);
      check("R4 wait count", 32'(n), 32'(ws));
    end

    // R5: mode 0 ignores ext_rdy low
    ext_rdy = 1'b0;
    wait_len(20'h01234, n);
    check("R5 ext ignored in mode 0", 32'(n), 3);

    // R6: miss keeps ready
    c = 16'h8F38 | 16'h0003;
    reg_access(1'b1, c);
    wait_len(20'h10000, n);
    check("R6 miss no wait", 32'(n), 0);

    // R5: mode 1 holds until ext_rdy
    c = 16'h8F38 | 16'h0005;
    reg_access(1'b1, c);
    wait_len(20'h00100, n);
    check("R5 held by ext_rdy", 32'(n), 20);
    ext_rdy = 1'b1; #1;
    check("R5 released by ext_rdy", 32'(bus_rdy), 1);

    // R4: no tick, no progress
    c = 16'h8F38 | 16'h0002;
    reg_access(1'b1, c);
    t_tick = 1'b0;
    @(negedge clk); addr = 20'h00001; cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    repeat (4) @(negedge clk);
    #1; check("R4 stalled without tick", 32'(bus_rdy), 0);
    t_tick = 1'b1;
    @(negedge clk); #1; check("R4 one tick left", 32'(bus_rdy), 0);
    @(negedge clk); #1; check("R4 done after ticks", 32'(bus_rdy), 1);

    // R7/R8 directed, strap high
    c = 16'h8F38 | 16'h00C0;
    reg_access(1'b1, c);
    probe("R7 strap high hit", c, 20'h0FFFF);
    probe("R7 strap high miss", c, 20'h10000);
    c = 16'h8F38;
    reg_access(1'b1, c);
    probe("R7 bit clear", c, 20'h00000);

    // Strap low: re-reset, re-arm, flag must stay low
    do_reset(1'b0);
    addr = 20'h00000; #1;
    check("R3 inert after re-reset", 32'(lcs_n), 1);
    c = 16'h8F38 | 16'h70C0;
    reg_access(1'b1, c);
    probe("R7 strap low", c, 20'h00000);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      c = 16'($urandom) | 16'h8F38;
      reg_access(1'b1, 16'(c & ~16'h8F38) | 16'($urandom & 32'h8F38));
      #1; check("R9 random readback", 32'(reg_rdata), 32'(c));
      for (int k = 0; k < 3; k++) begin
        logic [20:0] lim = win_lim(c);
        logic [19:0] a;
        case ($urandom % 3)
          0: a = 20'(lim - 21'(1));
          1: a = 20'(lim);
          default: a = 20'($urandom);
        endcase
        probe((c[14:12] == 3'b010 || c[14:12] == 3'b100 ||
               c[14:12] == 3'b101 || c[14:12] == 3'b110) ? "R2 rand" : "R1 rand", c, a);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule